// File: doc/BRIEF.md
# Banked Memory Bus Decoder

This block sits between an 8-bit processor and its storage. It splits a 16-bit byte address space into two regions. The low 8 KB (0x0000–0x1FFF) is read/write RAM. The upper 56 KB (0x2000–0xFFFF) is a read-only window onto one bank of cartridge storage. One byte inside the RAM region, address 0x0028, is replaced by a read-only image of six push buttons.

The cartridge is a flat byte array. Each bank occupies 0xE000 bytes of it, and an 8-bit bank number selects one of up to 256 banks. The length of the current bank comes in on an input, and reads past that length return zero. Writes into the cartridge window are dropped without any side effect. Loading a bank number also raises a one-cycle request for the processor to restart at 0x2000.

The request side uses a valid-only stream with no back-pressure: every cycle with `cpu_req_valid` high is accepted. A read returns exactly one response beat on `cpu_rsp_valid` in the next cycle. There is no ready signal, so the consumer must take that beat. Writes produce no response. The RAM and the cartridge store are both synchronous: read data appears one cycle after their enable.

Top module: `bankdec_top`

## Requirements
- R1: A read at an address below 0x2000, other than 0x0028, asserts `ram_en` with `ram_we` low and `ram_addr` equal to address bits [12:0] in the request cycle. The next cycle returns `ram_rdata`.
- R2: A write at an address below 0x2000, other than 0x0028, asserts `ram_en` and `ram_we` in the request cycle, with `ram_wdata` equal to the write data. A later read of that address returns the written byte.
- R3: A write at 0x2000 or above asserts neither `ram_we` nor `cart_en`, and RAM contents are unchanged.
- R4: A read at address A ≥ 0x2000 whose offset A−0x2000 is below `cart_bank_len` asserts `cart_en` with `cart_addr` = bank×0xE000 + (A−0x2000). The next cycle returns `cart_rdata`.
- R5: The bank number is 0 after reset. A `bank_load` pulse with `bank_value` V makes V the bank for every request from the following cycle on, and raises `pc_reload` for exactly the one cycle after the pulse.
- R6: A read in the cartridge window whose offset is at or beyond `cart_bank_len` returns 0x00 and does not assert `cart_en`.
- R7: A read of 0x0028 does not assert `ram_en`. It returns a byte whose bits 0..5 are left, up, right, down, A and B (1 = pressed), as seen on `btn_raw` after a two-stage synchronizer. Bits 7:6 are zero.
- R8: A write to 0x0028 asserts neither `ram_we` nor `cart_en`, and a following read of 0x0028 still returns the buttons.
- R9: `cpu_rsp_valid` is high in the cycle after each read request and low after a write or an idle cycle.
- R10: During and right after reset, `cpu_rsp_valid` and `pc_reload` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Request beat present |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 16 | Byte address |
| cpu_req_wdata | input | 8 | Write data |
| cpu_rsp_valid | output | 1 | Read response beat |
| cpu_rsp_data | output | 8 | Read response data |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 13 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after enable |
| cart_en | output | 1 | Cartridge read enable |
| cart_addr | output | 24 | Linear cartridge byte address |
| cart_rdata | input | 8 | Cartridge read data, one cycle after enable |
| cart_bank_len | input | 16 | Populated bytes in the current bank (0..0xE000) |
| bank_load | input | 1 | Load a new bank number |
| bank_value | input | 8 | Bank number to load |
| pc_reload | output | 1 | Processor restart request toward 0x2000 |
| btn_raw | input | 6 | Asynchronous button levels |

## Verification
The bench targets the edges of the RAM window, using 0x1FFF, 0x2000 and 0xFFFF. A decoder that is off by one there writes the cartridge window into RAM or fetches RAM from cartridge storage. It probes the padding boundary at offsets len−1 and len, and also a zero-length bank. Getting that comparison wrong returns cartridge garbage instead of zero, or zeroes real data. It writes to the button byte and reads it back, to catch a design that lets the write land in RAM or shadow the inputs. It also loads banks, including 255, and reads in the cycle right after the load, which exposes a stale bank register, a multiply that overflows, or a missing restart pulse.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;
  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_BTN  = 2'd1,
    RGN_CART = 2'd2,
    RGN_PAD  = 2'd3
  } region_e;
endpackage

// File: rtl/bankdec_sync.sv
module bankdec_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bankdec_bank.sv
module bankdec_bank #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] value,
  output logic [BANK_W-1:0] bank,
  output logic              reload
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank   <= '0;
      reload <= 1'b0;
    end else begin
      reload <= load;
      if (load) bank <= value;
    end
  end
endmodule

// File: rtl/bankdec_decode.sv
module bankdec_decode
  import bankdec_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          RAM_BYTES = 8192,
  parameter int          BANK_W    = 8,
  parameter int          CART_W    = 24,
  parameter int          RAM_AW    = 13,
  parameter logic [15:0] BTN_ADDR  = 16'h0028
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] bank_len,
  output region_e           region,
  output logic [CART_W-1:0] cart_addr,
  output logic [RAM_AW-1:0] ram_addr
);
  localparam int BANK_BYTES = (1 << ADDR_W) - RAM_BYTES;
  localparam logic [ADDR_W-1:0] RAM_TOP = ADDR_W'(RAM_BYTES);

  logic [ADDR_W-1:0] offset;

  assign offset    = addr - RAM_TOP;
  assign ram_addr  = addr[RAM_AW-1:0];
  assign cart_addr = CART_W'(bank) * CART_W'(BANK_BYTES) + CART_W'(offset);

  always_comb begin
    if (addr < RAM_TOP)
      region = (addr == ADDR_W'(BTN_ADDR)) ? RGN_BTN : RGN_RAM;
    else
      region = (offset < bank_len) ? RGN_CART : RGN_PAD;
  end
endmodule

// File: rtl/bankdec_top.sv
module bankdec_top
  import bankdec_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          RAM_BYTES   = 8192,
  parameter int          BANK_W      = 8,
  parameter int          BTN_W       = 6,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] BTN_ADDR    = 16'h0028,
  localparam int RAM_AW     = $clog2(RAM_BYTES),
  localparam int BANK_BYTES = (1 << ADDR_W) - RAM_BYTES,
  localparam int CART_W     = $clog2(BANK_BYTES * (1 << BANK_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              cart_en,
  output logic [CART_W-1:0] cart_addr,
  input  logic [DATA_W-1:0] cart_rdata,
  input  logic [ADDR_W-1:0] cart_bank_len,
  input  logic              bank_load,
  input  logic [BANK_W-1:0] bank_value,
  output logic              pc_reload,
  input  logic [BTN_W-1:0]  btn_raw
);
  logic [BANK_W-1:0] bank;
  logic [BTN_W-1:0]  btn_sync;
  region_e           region;
  region_e           rsp_region;
  logic [DATA_W-1:0] btn_snap;
  logic              is_read;

  bankdec_sync #(.W(BTN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(btn_raw), .q(btn_sync)
  );

  bankdec_bank #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(bank_load), .value(bank_value),
    .bank(bank), .reload(pc_reload)
  );

  bankdec_decode #(
    .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .BANK_W(BANK_W),
    .CART_W(CART_W), .RAM_AW(RAM_AW), .BTN_ADDR(BTN_ADDR)
  ) u_dec (
    .addr(cpu_req_addr), .bank(bank), .bank_len(cart_bank_len),
    .region(region), .cart_addr(cart_addr), .ram_addr(ram_addr)
  );

  assign is_read   = cpu_req_valid && !cpu_req_we;
  assign ram_en    = cpu_req_valid && (region == RGN_RAM);
  assign ram_we    = ram_en && cpu_req_we;
  assign ram_wdata = cpu_req_wdata;
  assign cart_en   = is_read && (region == RGN_CART);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rsp_valid <= 1'b0;
      rsp_region    <= RGN_PAD;
      btn_snap      <= '0;
    end else begin
      cpu_rsp_valid <= is_read;
      if (is_read) begin
        rsp_region <= region;
        btn_snap   <= DATA_W'(btn_sync);
      end
    end
  end

  always_comb begin
    case (rsp_region)
      RGN_RAM:  cpu_rsp_data = ram_rdata;
      RGN_BTN:  cpu_rsp_data = btn_snap;
      RGN_CART: cpu_rsp_data = cart_rdata;
      default:  cpu_rsp_data = '0;
    endcase
  end
endmodule

// File: rtl/bankdec_chk.sv
module bankdec_chk #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          RAM_BYTES = 8192,
  parameter logic [15:0] BTN_ADDR  = 16'h0028
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_we,
  input logic [ADDR_W-1:0] cpu_req_addr,
  input logic              cpu_rsp_valid,
  input logic [DATA_W-1:0] cpu_rsp_data,
  input logic              ram_en,
  input logic              ram_we,
  input logic              cart_en,
  input logic              bank_load,
  input logic              pc_reload,
  input logic [ADDR_W-1:0] cart_bank_len
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(RAM_BYTES);

  p_rsp_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && !cpu_req_we) |=> cpu_rsp_valid);
  p_no_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req_valid && !cpu_req_we) |=> !cpu_rsp_valid);
  p_high_write_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_we && cpu_req_addr >= TOP) |-> (!ram_we && !cart_en));
  p_btn_write_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_we && cpu_req_addr == ADDR_W'(BTN_ADDR)) |-> !ram_we);
  p_reload_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |=> pc_reload);
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_en, cart_en}));
  p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && !cpu_req_we && cpu_req_addr >= TOP &&
     (cpu_req_addr - TOP) >= cart_bank_len) |=> (cpu_rsp_data == '0));
  p_btn_high_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && !cpu_req_we && cpu_req_addr == ADDR_W'(BTN_ADDR))
      |=> (cpu_rsp_data[7:6] == 2'b00));
endmodule

bind bankdec_top bankdec_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_BYTES(RAM_BYTES), .BTN_ADDR(BTN_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
  .cpu_req_addr(cpu_req_addr), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
  .ram_en(ram_en), .ram_we(ram_we), .cart_en(cart_en), .bank_load(bank_load),
  .pc_reload(pc_reload), .cart_bank_len(cart_bank_len)
);

// File: tb/bankdec_top_tb.sv
module bankdec_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_we = 1'b0;
  logic [15:0] cpu_req_addr = '0;
  logic [7:0]  cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic [7:0]  cpu_rsp_data;
  logic        ram_en, ram_we;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic        cart_en;
  logic [23:0] cart_addr;
  logic [7:0]  cart_rdata = '0;
  logic [15:0] cart_bank_len = 16'hE000;
  logic        bank_load = 1'b0;
  logic [7:0]  bank_value = '0;
  logic        pc_reload;
  logic [5:0]  btn_raw = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int cur_bank = 0;
  logic [7:0] ram_mem [8192];
  logic [7:0] shadow  [8192];

  always #(CLK_PERIOD/2) clk = ~clk;

  bankdec_top u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .cart_en(cart_en), .cart_addr(cart_addr),
    .cart_rdata(cart_rdata), .cart_bank_len(cart_bank_len), .bank_load(bank_load),
    .bank_value(bank_value), .pc_reload(pc_reload), .btn_raw(btn_raw)
  );

  function automatic logic [7:0] cart_model(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [23:0] exp_cart_addr(input int bank, input logic [15:0] a);
    return 24'(bank * 57344 + int'(a - 16'h2000));
  endfunction

  always @(posedge clk) begin
    if (ram_en && ram_we) ram_mem[ram_addr] <= ram_wdata;
    else if (ram_en) ram_rdata <= ram_mem[ram_addr];
    if (cart_en) cart_rdata <= cart_model(cart_addr);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic do_read(input logic [15:0] a);
    logic [7:0] expv;
    logic [15:0] off;
    string tag;
    off = a - 16'h2000;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = a;
    #1;
    if (a == 16'h0028) begin
      tag = "R7"; expv = {2'b00, btn_raw};
      check("R7 ram_en on button read", ram_en, 0);
    end else if (a < 16'h2000) begin
      tag = "R1"; expv = shadow[a[12:0]];
      check("R1 ram_en", ram_en, 1);
      check("R1 ram_addr", ram_addr, a[12:0]);
    end else if (off < cart_bank_len) begin
      tag = "R4"; expv = cart_model(exp_cart_addr(cur_bank, a));
      check("R4 cart_en", cart_en, 1);
      check("R4 cart_addr", cart_addr, exp_cart_addr(cur_bank, a));
    end else begin
      tag = "R6"; expv = 8'h00;
      check("R6 cart_en in padding", cart_en, 0);
    end
    @(negedge clk);
    cpu_req_valid = 1'b0;
    check("R9 rsp_valid after read", cpu_rsp_valid, 1);
    check(tag, cpu_rsp_data, expv);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = a; cpu_req_wdata = d;
    #1;
    if (a < 16'h2000 && a != 16'h0028) begin
      check("R2 ram_we", ram_we, 1);
      check("R2 ram_wdata", ram_wdata, d);
      shadow[a[12:0]] = d;
    end else if (a == 16'h0028) begin
      check("R8 ram_we on button write", ram_we, 0);
    end else begin
      check("R3 ram_we on high write", ram_we, 0);
      check("R3 cart_en on high write", cart_en, 0);
    end
    @(negedge clk);
    cpu_req_valid = 1'b0; cpu_req_we = 1'b0;
    check("R9 no rsp after write", cpu_rsp_valid, 0);
  endtask

  task automatic do_bank(input logic [7:0] v);
    @(negedge clk);
    bank_load = 1'b1; bank_value = v;
    @(negedge clk);
    bank_load = 1'b0;
    cur_bank = int'(v);
    check("R5 pc_reload pulse", pc_reload, 1);
  endtask

  task automatic set_btn(input logic [5:0] b);
    @(negedge clk);
    btn_raw = b;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) begin ram_mem[i] = 8'h00; shadow[i] = 8'h00; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10 rsp_valid in reset", cpu_rsp_valid, 0);
    check("R10 pc_reload in reset", pc_reload, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 pc_reload after reset", pc_reload, 0);
    check("R10 rsp_valid after reset", cpu_rsp_valid, 0);

    // R5: bank 0 after reset
    do_read(16'h2000);
    do_read(16'hFFFF);
    // R1/R2 window edges
    do_write(16'h1FFF, 8'hA5);
    do_read(16'h1FFF);
    do_write(16'h0000, 8'h3C);
    do_read(16'h0000);
    // R3: high write leaves RAM alone
    do_write(16'h2000, 8'h77);
    do_write(16'hFFFF, 8'h11);
    do_read(16'h0000);
    // R7/R8: buttons
    set_btn(6'b10_0101);
    do_read(16'h0028);
    do_write(16'h0028, 8'hFF);
    do_read(16'h0028);
    set_btn(6'b01_1010);
    do_read(16'h0028);
    do_read(16'h0027);
    do_read(16'h0029);
    // R5: load then read right after
    do_bank(8'd255);
    check("R5 pc_reload one cycle", pc_reload, 1);
    @(negedge clk);
    check("R5 pc_reload drops", pc_reload, 0);
    do_read(16'hFFFF);
    do_bank(8'd3);
    do_read(16'h2001);
    // R6: padding boundary
    cart_bank_len = 16'h0100;
    do_read(16'h20FF);
    do_read(16'h2100);
    cart_bank_len = 16'h0000;
    do_read(16'h2000);
    cart_bank_len = 16'hE000;
    do_read(16'hFFFF);

    for (int i = 0; i < 600; i++) begin
      int k;
      logic [15:0] a;
      k = int'($urandom_range(0, 99));
      if (k < 25) a = 16'($urandom_range(0, 16'h1FFF));
      else if (k < 30) a = 16'h0028;
      else a = 16'($urandom_range(16'h2000, 16'hFFFF));
      if (k % 7 == 0) cart_bank_len = 16'($urandom_range(0, 16'hE000));
      if (k == 99) do_bank(8'($urandom_range(0, 255)));
      else if (k == 98) set_btn(6'($urandom_range(0, 63)));
      else if (k % 3 == 0) do_write(a, 8'($urandom_range(0, 255)));
      else do_read(a);
    end
    for (int i = 0; i < 64; i++) do_read(16'(i * 128 + 5));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule